// File: doc/BRIEF.md
# T3 Framing Error Performance Monitor

This block sits behind a T3 receive framer. It watches the framing-bit results and a set of error strobes. It raises a severely errored framing event whenever too many recent framing bits were wrong. It also keeps error totals in saturating live counters. Each total is moved into a holding register that the rest of the chip reads.

A transfer happens on one of two triggers. In automatic mode it happens on each one-second tick. In manual mode it happens on a rising edge of either the host update control or the external update strobe. The transfer clears every live counter in the same cycle. Any error that arrives during that cycle is folded into the snapshot, so no count is lost between intervals. The one-second tick also sets a latched event flag, and that flag stays set until it is acknowledged.

Top module: `t3_perf_mon`

## Requirements
- R1: While `rst` is high and on the first cycle after it, every holding register reads zero and `sef_evt`, `sec_evt` and `upd_done` are low.
- R2: Only cycles with `fbit_vld` high shift `fbit_err` into a 16-bit history of framing-bit results. `sef_evt` is high for exactly the one cycle after a valid framing bit when that history, including the new bit, holds 3 or more errors. It is low after any cycle without a valid bit.
- R3: A cycle with `lof` high empties the history and suppresses `sef_evt` on the next cycle. After that, earlier errors no longer count toward the threshold.
- R4: Counter 0 counts cycles with `fbit_vld` and `fbit_err` both high. Counter k (k = 1 to 5) counts cycles with `err_strb[k-1]` high. Counter k occupies `hold_cnt[16*k+15:16*k]`.
- R5: A live counter that reaches FFFFh stays at FFFFh until a transfer takes place. It does not wrap.
- R6: A transfer loads each holding register with the live count plus any event in the transfer cycle, saturated at FFFFh. The live counter restarts from zero in that same cycle. Between transfers the holding registers do not change.
- R7: With `man_mode` high, the cycle in which `host_upd` is first seen high after being low performs a transfer. Holding `host_upd` high does not transfer again.
- R8: With `man_mode` high, a rising edge of `ext_upd` performs a transfer in the same way.
- R9: With `man_mode` low, only `sec_tick` performs transfers, and `host_upd` and `ext_upd` have no effect. With `man_mode` high, `sec_tick` performs no transfer.
- R10: `sec_evt` is set the cycle after `sec_tick` in either mode. It is cleared the cycle after `sec_ack` is high, and a tick in the same cycle as the acknowledge keeps it set.
- R11: `upd_done` is high for one cycle, in the cycle after each transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fbit_vld | input | 1 | A framing bit is present this cycle |
| fbit_err | input | 1 | The present framing bit is in error |
| lof | input | 1 | Framer reports loss of frame; empties the history |
| err_strb | input | 5 | One-cycle strobes for the other five counted events |
| sec_tick | input | 1 | One-second timer boundary |
| sec_ack | input | 1 | Clears the latched one-second event |
| man_mode | input | 1 | 1 selects manual transfer, 0 selects transfer on the tick |
| host_upd | input | 1 | Host manual update control, edge sensitive |
| ext_upd | input | 1 | External update strobe, edge sensitive |
| hold_cnt | output | 96 | Six 16-bit holding registers, counter k at bits 16k+15:16k |
| sef_evt | output | 1 | Severely errored framing event pulse |
| sec_evt | output | 1 | Latched one-second event |
| upd_done | output | 1 | Pulse after each transfer |

## Verification
The framing-bit detector gets three kinds of stream. In the first, errors are spaced every eighth bit, so two errors at most fall in the window and the threshold is never reached. In the second, errors are spaced every sixth bit, which puts exactly three in the window and so probes the edge of the threshold. Long invalid gaps between bits show whether the window moves only on valid bits. A loss-of-frame placed between two error groups shows that the history is really emptied, not just masked for one cycle. The counters get random strobes under both automatic and manual transfer. Update controls are held high across cycles to separate edge triggering from level triggering, and ticks arrive in manual mode to check that they do not transfer. Transfers land on cycles that also carry events, to catch lost counts. A run of more than 65535 straight events shows saturation, as opposed to wrap-around.

// File: rtl/t3pm_pkg.sv
package t3pm_pkg;

  localparam int unsigned MAX_WIN = 64;

  function automatic int unsigned count_ones(input logic [MAX_WIN-1:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < MAX_WIN; i++) begin
      n += {31'd0, v[i]};
    end
    return n;
  endfunction

  function automatic logic [15:0] sat_add16(input logic [15:0] a, input logic b);
    logic [16:0] s;
    s = {1'b0, a} + {16'd0, b};
    return s[16] ? 16'hFFFF : s[15:0];
  endfunction

endpackage

// File: rtl/t3pm_sef_window.sv
module t3pm_sef_window
  import t3pm_pkg::*;
#(
  parameter int unsigned WIN_LEN    = 16,
  parameter int unsigned SEF_THRESH = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic fbit_vld,
  input  logic fbit_err,
  input  logic lof,
  output logic sef_evt
);

  localparam int unsigned PAD = MAX_WIN - WIN_LEN;

  logic [WIN_LEN-1:0] hist_q;
  logic [WIN_LEN-1:0] hist_nxt;
  logic               over_thresh;

  initial begin
    if (WIN_LEN < 2 || WIN_LEN > MAX_WIN) $error("WIN_LEN out of range");
  end

  always_comb begin
    hist_nxt    = {hist_q[WIN_LEN-2:0], fbit_err};
    over_thresh = count_ones({{PAD{1'b0}}, hist_nxt}) >= SEF_THRESH;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q  <= '0;
      sef_evt <= 1'b0;
    end else if (lof) begin
      hist_q  <= '0;
      sef_evt <= 1'b0;
    end else if (fbit_vld) begin
      hist_q  <= hist_nxt;
      sef_evt <= over_thresh;
    end else begin
      sef_evt <= 1'b0;
    end
  end

  p_quiet_without_bit_r2: assert property (@(posedge clk) disable iff (rst)
    !fbit_vld |=> !sef_evt);

  p_history_frozen_r2: assert property (@(posedge clk) disable iff (rst)
    (!fbit_vld && !lof) |=> $stable(hist_q));

  p_lof_empties_r3: assert property (@(posedge clk) disable iff (rst)
    lof |=> (count_ones({{PAD{1'b0}}, hist_q}) == 0) && !sef_evt);

  p_clean_bit_needs_history_r2: assert property (@(posedge clk) disable iff (rst)
    (fbit_vld && !lof && !fbit_err &&
     count_ones({{PAD{1'b0}}, hist_q}) < SEF_THRESH) |=> !sef_evt);

endmodule

// File: rtl/t3pm_err_counter.sv
module t3pm_err_counter
  import t3pm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             upd,
  output logic [CNT_W-1:0] hold
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] live_q;
  logic [CNT_W-1:0] live_sum;

  always_comb begin
    if (live_q == CNT_MAX) live_sum = CNT_MAX;
    else                   live_sum = live_q + CNT_W'(inc);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= '0;
      hold   <= '0;
    end else if (upd) begin
      hold   <= live_sum;
      live_q <= '0;
    end else begin
      live_q <= live_sum;
    end
  end

  p_no_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (live_q == CNT_MAX && !upd) |=> live_q == CNT_MAX);

  p_hold_between_transfers_r6: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(hold));

  p_count_monotonic_r4: assert property (@(posedge clk) disable iff (rst)
    (!upd && !$past(upd)) |-> live_q >= $past(live_q));

endmodule

// File: rtl/t3pm_upd_ctrl.sv
module t3pm_upd_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic man_mode,
  input  logic sec_tick,
  input  logic sec_ack,
  input  logic host_upd,
  input  logic ext_upd,
  output logic upd_go,
  output logic upd_done,
  output logic sec_evt
);

  logic host_q;
  logic ext_q;
  logic host_rise;
  logic ext_rise;

  always_comb begin
    host_rise = host_upd && !host_q;
    ext_rise  = ext_upd && !ext_q;
    upd_go    = man_mode ? (host_rise || ext_rise) : sec_tick;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_q   <= 1'b0;
      ext_q    <= 1'b0;
      upd_done <= 1'b0;
      sec_evt  <= 1'b0;
    end else begin
      host_q   <= host_upd;
      ext_q    <= ext_upd;
      upd_done <= upd_go;
      if (sec_tick)     sec_evt <= 1'b1;
      else if (sec_ack) sec_evt <= 1'b0;
    end
  end

  p_done_after_go_r11: assert property (@(posedge clk) disable iff (rst)
    upd_go |=> upd_done);

  p_done_single_r11: assert property (@(posedge clk) disable iff (rst)
    !upd_go |=> !upd_done);

  p_level_no_retrigger_r7: assert property (@(posedge clk) disable iff (rst)
    (man_mode && host_upd && $past(host_upd) && !(ext_upd && !$past(ext_upd)))
      |-> !upd_go);

  p_auto_only_tick_r9: assert property (@(posedge clk) disable iff (rst)
    (!man_mode && !sec_tick) |=> !upd_done);

  p_tick_latches_r10: assert property (@(posedge clk) disable iff (rst)
    sec_tick |=> sec_evt);

  p_ack_clears_r10: assert property (@(posedge clk) disable iff (rst)
    (sec_ack && !sec_tick) |=> !sec_evt);

endmodule

// File: rtl/t3_perf_mon.sv
module t3_perf_mon #(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned NUM_CNT    = 6,
  parameter int unsigned WIN_LEN    = 16,
  parameter int unsigned SEF_THRESH = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       fbit_vld,
  input  logic                       fbit_err,
  input  logic                       lof,
  input  logic [NUM_CNT-2:0]         err_strb,
  input  logic                       sec_tick,
  input  logic                       sec_ack,
  input  logic                       man_mode,
  input  logic                       host_upd,
  input  logic                       ext_upd,
  output logic [NUM_CNT*CNT_W-1:0]   hold_cnt,
  output logic                       sef_evt,
  output logic                       sec_evt,
  output logic                       upd_done
);

  logic               upd_go;
  logic [NUM_CNT-1:0] cnt_inc;

  t3pm_sef_window #(
    .WIN_LEN   (WIN_LEN),
    .SEF_THRESH(SEF_THRESH)
  ) u_window (
    .clk     (clk),
    .rst     (rst),
    .fbit_vld(fbit_vld),
    .fbit_err(fbit_err),
    .lof     (lof),
    .sef_evt (sef_evt)
  );

  t3pm_upd_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .man_mode(man_mode),
    .sec_tick(sec_tick),
    .sec_ack (sec_ack),
    .host_upd(host_upd),
    .ext_upd (ext_upd),
    .upd_go  (upd_go),
    .upd_done(upd_done),
    .sec_evt (sec_evt)
  );

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    if (k == 0) begin : g_fbit
      assign cnt_inc[k] = fbit_vld & fbit_err;
    end else begin : g_strb
      assign cnt_inc[k] = err_strb[k-1];
    end

    t3pm_err_counter #(
      .CNT_W(CNT_W)
    ) u_cnt (
      .clk (clk),
      .rst (rst),
      .inc (cnt_inc[k]),
      .upd (upd_go),
      .hold(hold_cnt[k*CNT_W +: CNT_W])
    );
  end

  p_outputs_quiet_after_reset_r1: assert property (@(posedge clk)
    $fell(rst) |-> (hold_cnt == '0) && !sef_evt && !sec_evt && !upd_done);

  p_hold_moves_only_on_transfer_r6: assert property (@(posedge clk) disable iff (rst)
    !upd_go |=> $stable(hold_cnt));

endmodule

// File: tb/test_t3_perf_mon.sv
module test_t3_perf_mon;

  localparam int NC = 6;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fbit_vld = 1'b0, fbit_err = 1'b0, lof = 1'b0;
  logic [NC-2:0] err_strb = '0;
  logic          sec_tick = 1'b0, sec_ack = 1'b0, man_mode = 1'b0;
  logic          host_upd = 1'b0, ext_upd = 1'b0;
  logic [NC*CW-1:0] hold_cnt;
  logic          sef_evt, sec_evt, upd_done;

  always #5 clk = ~clk;

  t3_perf_mon i_t3_perf_mon (
    .clk(clk), .rst(rst), .fbit_vld(fbit_vld), .fbit_err(fbit_err), .lof(lof),
    .err_strb(err_strb), .sec_tick(sec_tick), .sec_ack(sec_ack),
    .man_mode(man_mode), .host_upd(host_upd), .ext_upd(ext_upd),
    .hold_cnt(hold_cnt), .sef_evt(sef_evt), .sec_evt(sec_evt), .upd_done(upd_done)
  );

  // reference model state
  int  m_live [NC];
  int  m_hold [NC];
  bit  m_win [$];
  bit  m_sef, m_sec, m_done, m_hq, m_eq;
  int  vectors = 0, miscompares = 0, cycles = 0;
  bit  done_flag = 0;
  string req = "R1";

  always @(posedge clk) begin
    bit go, ev;
    int n;
    if (rst) begin
      foreach (m_live[i]) begin m_live[i] = 0; m_hold[i] = 0; end
      m_win.delete(); m_sef = 0; m_sec = 0; m_done = 0; m_hq = 0; m_eq = 0;
    end else begin
      go = man_mode ? ((host_upd && !m_hq) || (ext_upd && !m_eq)) : sec_tick;
      m_done = go;
      for (int i = 0; i < NC; i++) begin
        ev = (i == 0) ? (fbit_vld && fbit_err) : err_strb[i-1];
        n = m_live[i] + (ev ? 1 : 0);
        if (n > 65535) n = 65535;
        if (go) begin m_hold[i] = n; m_live[i] = 0; end
        else m_live[i] = n;
      end
      if (lof) begin
        m_win.delete(); m_sef = 0;
      end else if (fbit_vld) begin
        m_win.push_back(fbit_err);
        if (m_win.size() > 16) void'(m_win.pop_front());
        n = 0;
        foreach (m_win[j]) n += m_win[j];
        m_sef = (n >= 3);
      end else m_sef = 0;
      if (sec_tick) m_sec = 1; else if (sec_ack) m_sec = 0;
      m_hq = host_upd; m_eq = ext_upd;
    end
  end

  always @(negedge clk) begin
    bit bad;
    if (!done_flag) begin
      bad = 0;
      vectors++;
      for (int i = 0; i < NC; i++) begin
        if (hold_cnt[i*CW +: CW] != m_hold[i][15:0]) begin
          bad = 1;
          $display("FAIL %s hold[%0d] actual %h expected %h at %0t", req, i,
                   hold_cnt[i*CW +: CW], m_hold[i][15:0], $time);
        end
      end
      if (sef_evt !== m_sef) begin
        bad = 1; $display("FAIL %s sef_evt actual %b expected %b at %0t", req, sef_evt, m_sef, $time);
      end
      if (sec_evt !== m_sec) begin
        bad = 1; $display("FAIL %s sec_evt actual %b expected %b at %0t", req, sec_evt, m_sec, $time);
      end
      if (upd_done !== m_done) begin
        bad = 1; $display("FAIL %s upd_done actual %b expected %b at %0t", req, upd_done, m_done, $time);
      end
      if (bad) miscompares++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 190000 && !done_flag) begin
      done_flag = 1;
      miscompares++;
      $display("FAIL watchdog actual %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic one_tick();
    sec_tick = 1; @(negedge clk); sec_tick = 0;
  endtask

  task automatic fbit_stream(input int nbits, input int period, input int gap);
    for (int k = 0; k < nbits; k++) begin
      fbit_vld = 1; fbit_err = ((k % period) == 0);
      @(negedge clk);
      fbit_vld = 0; fbit_err = 0;
      wait_cyc(gap);
    end
  endtask

  initial begin
    // R1: reset state
    req = "R1";
    wait_cyc(4);
    rst = 0;
    wait_cyc(2);

    // R4 R6 R10 R11: random strobes, automatic transfers
    req = "R4 R6 R11";
    for (int t = 0; t < 600; t++) begin
      err_strb = 5'($urandom);
      fbit_vld = 1'($urandom); fbit_err = 1'($urandom);
      sec_tick = ((t % 47) == 46);
      sec_ack  = ((t % 61) == 30);
      @(negedge clk);
    end
    err_strb = 0; fbit_vld = 0; fbit_err = 0; sec_tick = 0; sec_ack = 0;
    wait_cyc(3);

    // R2: sparse errors never reach the threshold, then threshold exactly
    req = "R2";
    fbit_stream(40, 8, 2);
    fbit_stream(40, 6, 3);
    fbit_stream(20, 1, 0);
    fbit_stream(30, 17, 1);

    // R3: loss of frame empties the history
    req = "R3";
    fbit_stream(2, 1, 0);
    lof = 1; @(negedge clk); lof = 0;
    fbit_vld = 1; fbit_err = 1; @(negedge clk);
    fbit_vld = 0; fbit_err = 0; wait_cyc(2);
    fbit_vld = 1; fbit_err = 1; lof = 1; @(negedge clk);
    fbit_vld = 0; fbit_err = 0; lof = 0;
    fbit_stream(3, 1, 1);
    wait_cyc(2);

    // R7 R9: manual mode, host edge; held level and ticks do not transfer
    req = "R7 R9 R11";
    man_mode = 1;
    for (int t = 0; t < 120; t++) begin
      err_strb = 5'($urandom);
      fbit_vld = 1; fbit_err = 1'($urandom);
      host_upd = (t >= 20 && t < 50) || (t >= 90 && t < 92);
      sec_tick = ((t % 25) == 10);
      @(negedge clk);
    end
    host_upd = 0; sec_tick = 0; err_strb = 0; fbit_vld = 0; fbit_err = 0;
    wait_cyc(2);

    // R8: external strobe edge
    req = "R8";
    for (int t = 0; t < 60; t++) begin
      err_strb = 5'($urandom);
      ext_upd  = (t == 15) || (t >= 30 && t < 40);
      host_upd = (t == 30);
      @(negedge clk);
    end
    ext_upd = 0; host_upd = 0; err_strb = 0;
    wait_cyc(2);

    // R9: automatic mode ignores manual controls
    req = "R9";
    man_mode = 0;
    for (int t = 0; t < 60; t++) begin
      err_strb = 5'($urandom);
      host_upd = t[2];
      ext_upd  = t[3];
      @(negedge clk);
    end
    host_upd = 0; ext_upd = 0; err_strb = 0;
    one_tick();
    wait_cyc(2);

    // R5: saturation, then transfer of FFFFh
    req = "R5";
    man_mode = 1;
    err_strb = '1; fbit_vld = 1; fbit_err = 1;
    wait_cyc(65545);
    host_upd = 1; @(negedge clk); host_upd = 0;
    err_strb = 0; fbit_vld = 0; fbit_err = 0;
    wait_cyc(2);

    // R10: tick alone, ack alone, tick together with ack
    req = "R10";
    sec_ack = 1; @(negedge clk); sec_ack = 0;
    one_tick(); wait_cyc(2);
    sec_ack = 1; sec_tick = 1; @(negedge clk); sec_tick = 0; sec_ack = 0;
    wait_cyc(2);
    sec_ack = 1; @(negedge clk); sec_ack = 0;
    wait_cyc(3);

    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule